// File: doc/BRIEF.md
# Blanking-Locked DRAM Row Refresh Sequencer

This block issues RAS-only row refresh cycles to a dynamic memory. The cycles are grouped into short bursts that start when the horizontal blanking interval of a video timing chain begins. Because refresh happens only in blanking, it never competes with display fetches during the visible part of a line. There is no free-running interval timer. Each line contributes a fixed number of row cycles. A row counter carries on from where the previous burst stopped, so successive lines sweep the whole array.

A burst starts on the rising edge of `hblank_i`. It raises `busy_o` to hold off other bus requesters. Each row cycle begins only while `grant_i` is high. A row cycle drives the row address, holds `ras_n_o` low for a set number of clocks, and then precharges with `ras_n_o` high for a set number of clocks.

If blanking ends before every cycle of the burst has been granted, the rest of the burst is abandoned and a sticky missed flag is set. When the row counter wraps, the block emits a one-clock sweep pulse. A watchdog raises a sticky late flag when too many clocks pass between sweeps. As a sizing example, a 31.47 kHz line rate with three rows per line sweeps 256 rows in about 2.71 ms. That is within the 4 ms allowed by the larger parts, while 128-row parts need every row within 2 ms.

The controller has four states:
- IDLE. On a blank rise it moves to WAIT_GRANT and loads the burst count.
- WAIT_GRANT. If blanking has ended it returns to IDLE and records a miss. Otherwise, when the grant is present, it moves to RAS_LOW.
- RAS_LOW. When the low time expires it moves to PRECHARGE and steps the row counter.
- PRECHARGE. When the precharge time expires it moves to WAIT_GRANT if cycles remain, or to IDLE after the last cycle.

Top module: `blank_refresh_gen`

## Requirements
- R1: After synchronous active-high reset, `ras_n_o`=1, `busy_o`=0, `row_addr_o`=0, `sweep_done_o`=0, `missed_o`=0 and `sweep_late_o`=0.
- R2: A burst starts only on a 0-to-1 transition of `hblank_i`. With the grant held high, each blanking interval gives exactly CYCLES_PER_LINE falling edges on `ras_n_o`, however long blanking lasts.
- R3: Every low pulse on `ras_n_o` lasts exactly RAS_LOW_CLKS clocks. Between pulses, `ras_n_o` stays high for at least PRECHARGE_CLKS clocks.
- R4: `row_addr_o` is stable while `ras_n_o` is low. It advances by one after each cycle, wraps from ROWS-1 to 0 (after 128 rows when ROWS=128), and continues across lines.
- R5: `busy_o` rises in the clock after the blank rise is seen and falls when the last precharge ends. With the grant always high, it stays high for CYCLES_PER_LINE*(1+RAS_LOW_CLKS+PRECHARGE_CLKS) clocks per line.
- R6: No row cycle starts while `grant_i` is low. `busy_o` stays high while the block waits for the grant.
- R7: `ras_n_o` falls only when `hblank_i` was high at the preceding clock edge.
- R8: If `hblank_i` is low when the next cycle of a burst is due, the remaining cycles are dropped, `busy_o` falls, and `missed_o` is set and stays set until reset.
- R9: `sweep_done_o` is a one-clock pulse that coincides with `row_addr_o` returning to 0. There is one pulse per full sweep.
- R10: `sweep_late_o` is set when SWEEP_LIMIT clocks pass without a sweep pulse and stays set until reset. It stays clear while sweeps arrive in time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hblank_i | input | 1 | Horizontal blanking level from the video timing chain |
| grant_i | input | 1 | Memory bus grant |
| row_addr_o | output | $clog2(ROWS) | Row address for the refresh cycle |
| ras_n_o | output | 1 | Active-low row strobe |
| busy_o | output | 1 | Refresh burst in progress; holds off other requesters |
| sweep_done_o | output | 1 | One-clock pulse when the row counter wraps |
| missed_o | output | 1 | Sticky: a burst was cut short by the end of blanking |
| sweep_late_o | output | 1 | Sticky: the sweep interval exceeded SWEEP_LIMIT clocks |

## Verification
The bench builds the block with ROWS=128, which exercises the 7-bit wrap. A full sweep then takes only 43 lines. The other settings are CYCLES_PER_LINE=3, RAS_LOW_CLKS=2 and PRECHARGE_CLKS=2, which keep a burst at 15 clocks so short blanking windows can cut it off. SWEEP_LIMIT is 2500, which puts both a timely double sweep and an expired watchdog within a few thousand clocks.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT_GRANT,
        ST_RAS_LOW,
        ST_PRECHARGE
    } rfsh_state_e;
endpackage

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
    parameter int ROWS  = 256,
    parameter int ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o,
    output logic             wrap_o
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_o  <= '0;
            wrap_o <= 1'b0;
        end else begin
            wrap_o <= 1'b0;
            if (step_i) begin
                if (row_o == LAST_ROW) begin
                    row_o  <= '0;
                    wrap_o <= 1'b1;
                end else begin
                    row_o <= row_o + 1'b1;
                end
            end
        end
    end

    // R9: the wrap pulse is seen together with row zero
    p_wrap_at_zero_r9: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (row_o == '0));
endmodule

// File: rtl/sweep_watchdog.sv
module sweep_watchdog #(
    parameter int SWEEP_LIMIT = 400000
) (
    input  logic clk,
    input  logic rst,
    input  logic sweep_i,
    output logic late_o
);
    localparam int CNT_W = $clog2(SWEEP_LIMIT + 1);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(SWEEP_LIMIT);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            late_o <= 1'b0;
        end else begin
            if (sweep_i) begin
                cnt_q <= '0;
            end else if (cnt_q != LIMIT_V) begin
                cnt_q <= cnt_q + 1'b1;
            end
            late_o <= late_o | (cnt_q == LIMIT_V);
        end
    end

    // R10: once raised, the late flag is held until reset
    p_late_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        late_o |=> late_o);
endmodule

// File: rtl/blank_refresh_gen.sv
module blank_refresh_gen
    import rfsh_pkg::*;
#(
    parameter int ROWS            = 256,
    parameter int CYCLES_PER_LINE = 3,
    parameter int RAS_LOW_CLKS    = 4,
    parameter int PRECHARGE_CLKS  = 3,
    parameter int SWEEP_LIMIT     = 400000,
    parameter int ROW_W           = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hblank_i,
    input  logic             grant_i,
    output logic [ROW_W-1:0] row_addr_o,
    output logic             ras_n_o,
    output logic             busy_o,
    output logic             sweep_done_o,
    output logic             missed_o,
    output logic             sweep_late_o
);
    localparam int MAX_T  = (RAS_LOW_CLKS > PRECHARGE_CLKS) ? RAS_LOW_CLKS : PRECHARGE_CLKS;
    localparam int TMR_W  = $clog2(MAX_T + 1);
    localparam int LEFT_W = $clog2(CYCLES_PER_LINE + 1);
    localparam logic [TMR_W-1:0]  RAS_LD  = TMR_W'(RAS_LOW_CLKS - 1);
    localparam logic [TMR_W-1:0]  PRE_LD  = TMR_W'(PRECHARGE_CLKS - 1);
    localparam logic [LEFT_W-1:0] BURST_N = LEFT_W'(CYCLES_PER_LINE);

    rfsh_state_e       state_q, state_d;
    logic [TMR_W-1:0]  tmr_q, tmr_d;
    logic [LEFT_W-1:0] left_q, left_d;
    logic              blank_q;
    logic              blank_rise;
    logic              miss_set;
    logic              row_step;

    assign blank_rise = hblank_i & ~blank_q;

    // Next-state logic
    always_comb begin
        state_d  = state_q;
        tmr_d    = tmr_q;
        left_d   = left_q;
        miss_set = 1'b0;
        row_step = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (blank_rise) begin
                    state_d = ST_WAIT_GRANT;
                    left_d  = BURST_N;
                end
            end
            ST_WAIT_GRANT: begin
                if (!hblank_i) begin
                    state_d  = ST_IDLE;
                    miss_set = 1'b1;
                    left_d   = '0;
                end else if (grant_i) begin
                    state_d = ST_RAS_LOW;
                    tmr_d   = RAS_LD;
                end
            end
            ST_RAS_LOW: begin
                if (tmr_q == '0) begin
                    state_d  = ST_PRECHARGE;
                    tmr_d    = PRE_LD;
                    row_step = 1'b1;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
            ST_PRECHARGE: begin
                if (tmr_q == '0) begin
                    left_d  = left_q - 1'b1;
                    state_d = (left_q == LEFT_W'(1)) ? ST_IDLE : ST_WAIT_GRANT;
                end else begin
                    tmr_d = tmr_q - 1'b1;
                end
            end
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            tmr_q    <= '0;
            left_q   <= '0;
            blank_q  <= 1'b0;
            missed_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            tmr_q    <= tmr_d;
            left_q   <= left_d;
            blank_q  <= hblank_i;
            missed_o <= missed_o | miss_set;
        end
    end

    // Output decode
    always_comb begin
        busy_o  = (state_q != ST_IDLE);
        ras_n_o = (state_q != ST_RAS_LOW);
    end

    refresh_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) i_rows (
        .clk    (clk),
        .rst    (rst),
        .step_i (row_step),
        .row_o  (row_addr_o),
        .wrap_o (sweep_done_o)
    );

    sweep_watchdog #(.SWEEP_LIMIT(SWEEP_LIMIT)) i_wdog (
        .clk     (clk),
        .rst     (rst),
        .sweep_i (sweep_done_o),
        .late_o  (sweep_late_o)
    );

    // R3: strobe stays low until its hold time is used up
    p_ras_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RAS_LOW && tmr_q != '0) |=> !ras_n_o);
    // R3: a released strobe is high for at least one more clock
    p_ras_release_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n_o) |=> ras_n_o);
    // R4: address does not move while the row is open
    p_row_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (!ras_n_o && !$past(ras_n_o)) |-> $stable(row_addr_o));
    // R5: an open row always lies inside a busy window
    p_busy_cover_r5: assert property (@(posedge clk) disable iff (rst)
        !ras_n_o |-> busy_o);
    // R6: no cycle starts without a grant
    p_grant_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT_GRANT && !grant_i) |=> ras_n_o);
    // R7: strobe only falls during blanking
    p_blank_gate_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n_o) |-> $past(hblank_i));
    // R8: the missed flag is sticky
    p_missed_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        missed_o |=> missed_o);
endmodule

// File: tb/test_blank_refresh_gen.sv
module test_blank_refresh_gen;
    localparam int ROWS  = 128;
    localparam int CYC   = 3;
    localparam int RASW  = 2;
    localparam int PREW  = 2;
    localparam int LIMIT = 2500;
    localparam int ROW_W = $clog2(ROWS);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hblank = 1'b0;
    logic grant = 1'b0;
    logic [ROW_W-1:0] row;
    logic ras_n, busy, sweep, missed, late;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // monitor state
    int falls = 0, busy_clks = 0, sweeps = 0;
    int exp_row = 0, low_run = 0, high_run = 1000;
    logic prev_ras = 1'b1, prev_blank = 1'b0;

    always #4 clk = ~clk;

    blank_refresh_gen #(
        .ROWS(ROWS), .CYCLES_PER_LINE(CYC), .RAS_LOW_CLKS(RASW),
        .PRECHARGE_CLKS(PREW), .SWEEP_LIMIT(LIMIT)
    ) i_blank_refresh_gen (
        .clk(clk), .rst(rst), .hblank_i(hblank), .grant_i(grant),
        .row_addr_o(row), .ras_n_o(ras_n), .busy_o(busy),
        .sweep_done_o(sweep), .missed_o(missed), .sweep_late_o(late)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            exp_row = 0; prev_ras = 1'b1; low_run = 0; high_run = 1000; prev_blank = 1'b0;
        end else begin
            if (!ras_n && prev_ras) begin
                falls++;
                check(int'(row) == exp_row, "R4 row at strobe", int'(row), exp_row);
                check(prev_blank, "R7 strobe outside blanking", 0, 1);
                check(high_run >= PREW, "R3 precharge gap", high_run, PREW);
                exp_row = (exp_row + 1) % ROWS;
                low_run = 1;
            end else if (!ras_n) begin
                low_run++;
            end
            if (ras_n && !prev_ras) begin
                check(low_run == RASW, "R3 strobe width", low_run, RASW);
                high_run = 1;
            end else if (ras_n && high_run < 1000) begin
                high_run++;
            end
            if (busy) busy_clks++;
            if (sweep) sweeps++;
            prev_ras = ras_n;
            prev_blank = hblank;
        end
    end

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1; hblank = 1'b0; grant = 1'b0;
        clocks(3);
        rst = 1'b0;
        clocks(1);
    endtask

    task automatic line(input int hi, input int lo);
        hblank = 1'b1; clocks(hi);
        hblank = 1'b0; clocks(lo);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        check(ras_n == 1'b1, "R1 ras_n", ras_n, 1);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(row == '0, "R1 row", int'(row), 0);
        check(sweep == 1'b0, "R1 sweep", sweep, 0);
        check(missed == 1'b0, "R1 missed", missed, 0);
        check(late == 1'b0, "R1 late", late, 0);
    endtask

    task automatic t_one_line();
        int f0, b0;
        do_reset();
        grant = 1'b1;
        f0 = falls; b0 = busy_clks;
        line(20, 20);
        check(falls - f0 == CYC, "R2 cycles per line", falls - f0, CYC);
        check(busy_clks - b0 == CYC * (1 + RASW + PREW), "R5 busy length",
              busy_clks - b0, CYC * (1 + RASW + PREW));
        check(int'(row) == CYC, "R4 row after line", int'(row), CYC);
        check(missed == 1'b0, "R8 no miss", missed, 0);
    endtask

    task automatic t_long_blank();
        int f0;
        f0 = falls;
        line(60, 20);
        check(falls - f0 == CYC, "R2 no retrigger in long blank", falls - f0, CYC);
        check(int'(row) == 2 * CYC, "R4 continues across lines", int'(row), 2 * CYC);
    endtask

    task automatic t_grant_wait();
        int f0;
        do_reset();
        grant = 1'b0;
        f0 = falls;
        hblank = 1'b1;
        clocks(10);
        @(negedge clk);
        check(falls - f0 == 0, "R6 no cycle without grant", falls - f0, 0);
        check(busy == 1'b1, "R6 busy while waiting", busy, 1);
        @(posedge clk); #1;
        grant = 1'b1;
        clocks(30);
        hblank = 1'b0;
        clocks(20);
        check(falls - f0 == CYC, "R6 burst after grant", falls - f0, CYC);
    endtask

    task automatic t_missed();
        int f0;
        do_reset();
        grant = 1'b1;
        f0 = falls;
        line(3, 20);
        check(falls - f0 == 1, "R8 dropped cycles", falls - f0, 1);
        check(missed == 1'b1, "R8 miss flag", missed, 1);
        check(busy == 1'b0, "R8 busy released", busy, 0);
        check(int'(row) == 1, "R8 row after cut burst", int'(row), 1);
        line(20, 20);
        check(missed == 1'b1, "R8 miss flag sticky", missed, 1);
        do_reset();
        grant = 1'b0;
        f0 = falls;
        line(10, 10);
        check(falls - f0 == 0, "R8 no grant in blank", falls - f0, 0);
        check(missed == 1'b1, "R8 miss without grant", missed, 1);
        check(busy == 1'b0, "R8 busy released no grant", busy, 0);
    endtask

    task automatic t_sweep();
        int s0;
        do_reset();
        grant = 1'b1;
        s0 = sweeps;
        for (int i = 0; i < 86; i++) line(20, 20);
        check(sweeps - s0 == 2, "R9 sweep pulses", sweeps - s0, 2);
        check(int'(row) == (86 * CYC) % ROWS, "R4 row after wrap", int'(row), (86 * CYC) % ROWS);
        check(late == 1'b0, "R10 timely sweeps", late, 0);
    endtask

    task automatic t_watchdog();
        do_reset();
        clocks(LIMIT - 10);
        check(late == 1'b0, "R10 before limit", late, 0);
        clocks(20);
        check(late == 1'b1, "R10 after limit", late, 1);
        grant = 1'b1;
        line(20, 20);
        check(late == 1'b1, "R10 sticky", late, 1);
    endtask

    initial begin
        t_reset();
        t_one_line();
        t_long_blank();
        t_grant_wait();
        t_missed();
        t_sweep();
        t_watchdog();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule